// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block keeps a running sum of signed products over a stream of operand pairs, computing A(n+1) = S(n)·C(n) + A(n). One operand pair may enter on every clock. The product is formed in a three-stage multiplier pipeline. A single-cycle adder then adds it to the accumulator, and the accumulator's output feeds straight back into the adder's input. Dependent accumulations therefore issue back-to-back even though one operand pair takes four cycles from input to result.

Each operand pair carries its own valid flag and an optional clear flag. The flags travel down the pipeline beside the product. The accumulator changes only when a product tagged valid leaves the multiplier. If that product is also tagged clear, the accumulator is loaded with the product instead of adding it, which starts a new sum. Cycles without valid input pass through as bubbles and leave the sum alone. The accumulator carries guard bits above the full product width, so long sums do not wrap early.

Top module: `mac_pipe_top`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous) and on the first clock after it, acc_valid is 0 and acc_out is 0.
- R2: A pair accepted with op_valid=1 at a rising edge produces acc_valid=1, with its result on acc_out, right after the fourth rising edge counted from and including the accepting edge.
- R3: Pairs presented on consecutive cycles produce results on consecutive cycles, with acc_valid held at 1 and no stall.
- R4: A valid pair with op_clr=0 sets acc_out to the previous acc_out plus S·C, where S and C are two's-complement signed values.
- R5: A valid pair with op_clr=1 sets acc_out to the sign-extended product S·C, discarding the earlier sum.
- R6: A cycle with op_valid=0 produces acc_valid=0 four edges later and leaves acc_out unchanged in that cycle.
- R7: acc_out is ACC_W = 2·OP_W + GUARD_W bits wide (40 by default) and wraps only modulo 2^ACC_W, so sums larger than the 32-bit product are kept exactly.
- R8: op_clr has no effect when op_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operand pair present this cycle |
| op_clr | input | 1 | Load instead of add for this pair |
| op_s | input | OP_W | Signed sample operand |
| op_c | input | OP_W | Signed coefficient operand |
| acc_valid | output | 1 | acc_out was updated by a product this cycle |
| acc_out | output | ACC_W | Accumulated sum, two's complement |

## Verification
The assertions assume that op_valid and op_clr are defined at every rising edge after reset, and that op_clr matters only alongside op_valid. The latency check also assumes the pipeline is never stalled, because the block has no back-pressure. The stimulus drives all inputs on the falling edge from tasks, so they are always stable and defined at the sampling edge. Random gaps, and clear requests on idle cycles, are inserted on purpose so that the hold and ignore assumptions get exercised rather than merely respected.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // Control tag that travels beside each product through the pipeline
  typedef struct packed {
    logic vld;
    logic clr;
  } mac_tag_t;
endpackage

// File: rtl/mac_mul_pipe.sv
module mac_mul_pipe
  import mac_pkg::*;
#(
  parameter int OP_W       = 16,
  parameter int MUL_STAGES = 3,
  localparam int PROD_W    = 2 * OP_W,
  localparam int RET_N     = MUL_STAGES - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mac_tag_t          tag_i,
  input  logic [OP_W-1:0]   s_i,
  input  logic [OP_W-1:0]   c_i,
  output mac_tag_t          tag_o,
  output logic [PROD_W-1:0] prod_o
);

  function automatic logic [PROD_W-1:0] smul(input logic [OP_W-1:0] a,
                                             input logic [OP_W-1:0] b);
    logic signed [PROD_W-1:0] ea;
    logic signed [PROD_W-1:0] eb;
    ea = PROD_W'($signed(a));
    eb = PROD_W'($signed(b));
    return PROD_W'(ea * eb);
  endfunction

  // stage 1: operand capture
  mac_tag_t          tag1_q;
  logic [OP_W-1:0]   s1_q, c1_q;
  // stage 2: product
  mac_tag_t          tag2_q;
  logic [PROD_W-1:0] p2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag1_q <= '0;
      s1_q   <= '0;
      c1_q   <= '0;
      tag2_q <= '0;
      p2_q   <= '0;
    end else begin
      tag1_q.vld <= tag_i.vld;
      tag1_q.clr <= tag_i.vld & tag_i.clr;
      s1_q       <= s_i;
      c1_q       <= c_i;
      tag2_q     <= tag1_q;
      p2_q       <= smul(s1_q, c1_q);
    end
  end

  // retiming stages behind the multiplier
  mac_tag_t          tag_r [RET_N+1];
  logic [PROD_W-1:0] p_r   [RET_N+1];
  assign tag_r[0] = tag2_q;
  assign p_r[0]   = p2_q;

  for (genvar g = 0; g < RET_N; g++) begin : g_ret
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_r[g+1] <= '0;
        p_r[g+1]   <= '0;
      end else begin
        tag_r[g+1] <= tag_r[g];
        p_r[g+1]   <= p_r[g];
      end
    end
  end

  assign tag_o  = tag_r[RET_N];
  assign prod_o = p_r[RET_N];

  // idle input never enters the pipe as a clear
  assert_clr_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tag_i.vld) |=> !tag1_q.clr);

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int PROD_W = 32,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mac_tag_t          tag_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic              vld_o,
  output logic [ACC_W-1:0]  acc_o
);

  function automatic logic [ACC_W-1:0] sext(input logic [PROD_W-1:0] p);
    return ACC_W'($signed(p));
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] add_in;   // zero-cycle feedback operand
  logic [ACC_W-1:0] acc_nxt;
  logic             acc_en;   // adder enabled only on a valid product

  assign acc_en  = tag_i.vld;
  assign add_in  = tag_i.clr ? '0 : acc_q;
  assign acc_nxt = add_in + sext(prod_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= acc_en;
      if (acc_en) acc_q <= acc_nxt;
    end
  end

  assign acc_o = acc_q;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en) |=> ($stable(acc_q) && !vld_o));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && tag_i.clr) |=> (acc_q == sext($past(prod_i))));

  assert_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !tag_i.clr) |=> ((acc_q - $past(acc_q)) == sext($past(prod_i))));

endmodule

// File: rtl/mac_pipe_top.sv
module mac_pipe_top
  import mac_pkg::*;
#(
  parameter int OP_W       = 16,
  parameter int GUARD_W    = 8,
  parameter int MUL_STAGES = 3,
  localparam int PROD_W    = 2 * OP_W,
  localparam int ACC_W     = PROD_W + GUARD_W,
  localparam int LAT       = MUL_STAGES + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_clr,
  input  logic [OP_W-1:0]  op_s,
  input  logic [OP_W-1:0]  op_c,
  output logic             acc_valid,
  output logic [ACC_W-1:0] acc_out
);

  mac_tag_t          in_tag;
  mac_tag_t          mul_tag;
  logic [PROD_W-1:0] mul_prod;

  assign in_tag.vld = op_valid;
  assign in_tag.clr = op_clr;

  mac_mul_pipe #(.OP_W(OP_W), .MUL_STAGES(MUL_STAGES)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .tag_i  (in_tag),
    .s_i    (op_s),
    .c_i    (op_c),
    .tag_o  (mul_tag),
    .prod_o (mul_prod)
  );

  mac_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tag_i  (mul_tag),
    .prod_i (mul_prod),
    .vld_o  (acc_valid),
    .acc_o  (acc_out)
  );

  // independent valid shadow used only by the latency assertion
  logic [LAT-1:0] vld_shadow;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_shadow <= '0;
    else        vld_shadow <= {vld_shadow[LAT-2:0], op_valid};
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid == vld_shadow[LAT-1]);

  assert_reset_R1: assert property (@(posedge clk)
    (!rst_n) |=> (!acc_valid && acc_out == '0));

endmodule

// File: tb/mac_pipe_top_tb_top.sv
`timescale 1ns/1ps
module mac_pipe_top_tb_top;
  localparam int OP_W  = 16;
  localparam int ACC_W = 40;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             op_valid = 1'b0;
  logic             op_clr = 1'b0;
  logic [OP_W-1:0]  op_s = '0;
  logic [OP_W-1:0]  op_c = '0;
  logic             acc_valid;
  logic [ACC_W-1:0] acc_out;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2.5 clk = ~clk;

  mac_pipe_top dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_clr(op_clr),
    .op_s(op_s), .op_c(op_c), .acc_valid(acc_valid), .acc_out(acc_out)
  );

  // reference: four-deep record of accepted inputs, result after the 4th edge
  logic             h_v [4];
  logic             h_c [4];
  logic [ACC_W-1:0] h_p [4];
  logic             m_vld;
  logic [ACC_W-1:0] m_acc;

  function automatic logic [ACC_W-1:0] ref_prod(input logic [OP_W-1:0] s,
                                                input logic [OP_W-1:0] c);
    longint a, b;
    a = longint'($signed(s));
    b = longint'($signed(c));
    return ACC_W'(a * b);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin h_v[i] = 0; h_c[i] = 0; h_p[i] = '0; end
      m_vld = 0; m_acc = '0;
    end else begin
      for (int i = 3; i > 0; i--) begin h_v[i] = h_v[i-1]; h_c[i] = h_c[i-1]; h_p[i] = h_p[i-1]; end
      h_v[0] = op_valid; h_c[0] = op_clr; h_p[0] = ref_prod(op_s, op_c);
      m_vld = h_v[3];
      if (h_v[3]) m_acc = (h_c[3] ? '0 : m_acc) + h_p[3];
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [ACC_W:0] act, input logic [ACC_W:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_model(input string req);
    check(req, {acc_valid, acc_out}, {m_vld, m_acc});
  endtask

  // one falling edge: compare with model, then drive next inputs
  task automatic step(input string req, input logic v, input logic cl,
                      input logic [OP_W-1:0] s, input logic [OP_W-1:0] c);
    @(negedge clk);
    check_model(req);
    op_valid = v; op_clr = cl; op_s = s; op_c = c;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 5; i++) step(req, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_reset_r1();
    @(negedge clk);
    check("R1 during reset", {acc_valid, acc_out}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {acc_valid, acc_out}, '0);
  endtask

  task automatic t_latency_r2();
    @(negedge clk);
    op_valid = 1; op_clr = 1; op_s = 16'd7; op_c = 16'd9;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      op_valid = 0; op_clr = 0;
      check("R2 valid timing", {40'd0, acc_valid}, {40'd0, (i == 4)});
    end
    check("R2 value", {1'b0, acc_out}, {1'b0, 40'd63});
  endtask

  task automatic t_stream_r3_r4();
    step("R4", 1, 1, 16'd3, 16'd4);
    step("R4", 1, 0, 16'hFFFE, 16'd5);
    step("R4", 1, 0, 16'd100, 16'hFF9C);
    step("R4", 1, 0, 16'h8000, 16'h7FFF);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op_valid = 0;
      check("R3 back-to-back valid", {40'd0, acc_valid}, 41'd1);
    end
    // 12 - 10 - 10000 - 1073709056
    check("R4 signed sum", {1'b0, acc_out}, {1'b0, 40'(-64'sd1073719054)});
    drain("R4");
  endtask

  task automatic t_clear_r5();
    step("R5", 1, 1, 16'd1000, 16'd1000);
    step("R5", 1, 1, 16'hFFFF, 16'd2);
    drain("R5");
    check("R5 load replaces sum", {acc_valid, acc_out}, {1'b0, 40'hFF_FFFF_FFFE});
  endtask

  task automatic t_bubbles_r6();
    logic [ACC_W-1:0] held;
    step("R6", 1, 1, 16'd11, 16'd13);
    for (int i = 0; i < 80; i++)
      step("R6", ($urandom % 3) != 0, ($urandom % 17) == 0,
           OP_W'($urandom), OP_W'($urandom));
    drain("R6");
    held = acc_out;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R6 idle hold", {acc_valid, acc_out}, {1'b0, held});
    end
  endtask

  task automatic t_guard_r7();
    step("R7", 1, 1, 16'h8000, 16'h8000);
    for (int i = 0; i < 7; i++) step("R7", 1, 0, 16'h8000, 16'h8000);
    drain("R7");
    check("R7 guard bits", {1'b0, acc_out}, {1'b0, 40'h02_0000_0000});
  endtask

  task automatic t_clr_ignored_r8();
    step("R8", 1, 1, 16'd5, 16'd5);
    step("R8", 0, 1, 16'd9, 16'd9);
    step("R8", 1, 0, 16'd2, 16'd3);
    drain("R8");
    check("R8 idle clear ignored", {1'b0, acc_out}, {1'b0, 40'd31});
  endtask

  initial begin
    t_reset_r1();
    t_latency_r2();
    t_stream_r3_r4();
    t_clear_r5();
    t_bubbles_r6();
    t_guard_r7();
    t_clr_ignored_r8();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule